// File: doc/BRIEF.md
# Third-Order Cascaded Divide-Ratio Modulator

This block turns a static integer-plus-fraction frequency setting into a stream of whole-number division ratios for a multimodulus divider inside a fractional-N PLL. Three first-order accumulator stages are chained. The first stage adds the constant fraction. Each later stage adds the leftover residue of the stage before it. The overflow bit of each stage is its one-bit quantizer output. The second stage's overflow is passed through a first difference, and the third stage's overflow is passed through a second difference. These are added to the first stage's overflow to form a small signed correction. Over time the correction averages to the fraction, and the quantization error is pushed to high offsets by a third-order highpass shape.

The block runs on the divided-down feedback clock, so it produces one new ratio per divider output period. The integer word is added to the correction. The sum is clamped to the divider's legal 64 to 127 span, and a flag reports any clamp. A valid strobe marks ratios taken once the difference delays hold real history.

Top module: `mash_divratio_mod`

## Requirements
- R1: A synchronous reset clears all three accumulators and all difference delays. On the edge after reset, `div_ratio` is 64, `div_valid` is 0 and `out_of_range` is 0.
- R2: On each enabled edge, stage k adds its input to its accumulator modulo 2^FRAC_W. The carry out of that addition is the stage's one-bit output, and the wrapped sum becomes both the new accumulator value and the input of stage k+1. Stage 1's input is `frac_word`.
- R3: The correction is c1[t] + (c2[t] − c2[t−1]) + (c3[t] − 2·c3[t−1] + c3[t−2]). The delayed terms are zero right after reset. The correction always lies in −3 to +4.
- R4: `div_ratio` is registered. It shows `int_word` plus the correction of the enabled edge that loaded it.
- R5: After reset, or after `en` rises, the first three enabled edges leave `div_valid` at 0. From the fourth enabled edge on, `div_valid` is 1.
- R6: While `en` is low, the accumulators, the delays, `div_ratio` and `out_of_range` hold their values, and `div_valid` is 0.
- R7: With `frac_word` = 0 after reset, every valid output equals `int_word` and no carries occur.
- R8: If `int_word` plus the correction is below 64, `div_ratio` is 64 and `out_of_range` is 1.
- R9: If `int_word` plus the correction is above 127, `div_ratio` is 127 and `out_of_range` is 1. For sums from 64 to 127, `out_of_range` is 0.
- R10: With constant inputs and a mid-range integer, the sum of 2^FRAC_W consecutive valid outputs is within 3 of int_word·2^FRAC_W + frac_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider-output clock; one sample per edge |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable |
| frac_word | input | FRAC_W | Fractional tune word (units of 2^-FRAC_W) |
| int_word | input | INT_W | Integer tune word |
| div_ratio | output | INT_W | Registered division ratio for the divider |
| div_valid | output | 1 | Ratio is taken after the three-sample fill |
| out_of_range | output | 1 | Ratio was clamped to 64 or 127 |

## Verification
The in-line assertions check, on every edge, the properties that hold from one cycle to the next:
- the correction stays within −3 to +4;
- each carry comes with a residue that wrapped below the stage input;
- the ratio never leaves the 64–127 band, and a set flag means the ratio sits on a limit;
- an idle or just-enabled cycle keeps the valid strobe low;
- a zero fraction with idle accumulators produces no carries.

Some behaviours only the bench's scenarios can show, because they depend on the exact cycle-by-cycle sequence. These are:
- the exact carry order and the recombined value at each sample;
- the fill count after enable;
- the long-run mean, which must match the tuned ratio within three counts over one full accumulator period.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // Recombine the three one-bit stage outputs with their delayed copies:
  // c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3
  function automatic logic signed [3:0] mash_corr(
    input logic c1,
    input logic c2,
    input logic c2_d1,
    input logic c3,
    input logic c3_d1,
    input logic c3_d2
  );
    int t;
    t = int'(c1) + int'(c2) - int'(c2_d1)
      + int'(c3) - 2 * int'(c3_d1) + int'(c3_d2);
    return 4'(t);
  endfunction

  // Signed sum of integer word and correction, in plain int arithmetic
  function automatic int mash_total(input int int_val, input logic signed [3:0] corr);
    return int_val + int'(corr);
  endfunction

endpackage

// File: rtl/mash_accum.sv
module mash_accum #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         en,
  input  logic [W-1:0] in_word,
  output logic         carry,
  output logic [W-1:0] residue
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, in_word};
    carry   = sum[W];
    residue = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (srst)    acc_q <= '0;
    else if (en) acc_q <= residue;
  end

  // R2: a carry means the residue wrapped below the added input
  p_carry_wraps_r2: assert property (@(posedge clk) disable iff (srst)
    (en && carry) |-> (residue < in_word));

endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
  import mash_pkg::*;
(
  input  logic               clk,
  input  logic               srst,
  input  logic               en,
  input  logic               c1,
  input  logic               c2,
  input  logic               c3,
  output logic signed [3:0]  corr
);
  logic c2_d1, c3_d1, c3_d2;

  always_comb corr = mash_corr(c1, c2, c2_d1, c3, c3_d1, c3_d2);

  always_ff @(posedge clk) begin
    if (srst) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (en) begin
      c2_d1 <= c2;
      c3_d2 <= c3_d1;
      c3_d1 <= c3;
    end
  end

  // R3: recombined correction stays within -3..+4
  p_corr_span_r3: assert property (@(posedge clk) disable iff (srst)
    (corr >= -4'sd3) && (corr <= 4'sd4));

endmodule

// File: rtl/mash_limit.sv
module mash_limit
  import mash_pkg::*;
#(
  parameter int INT_W   = 7,
  parameter int DIV_MIN = 64,
  parameter int DIV_MAX = 127
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              en,
  input  logic [INT_W-1:0]  int_word,
  input  logic signed [3:0] corr,
  output logic [INT_W-1:0]  div_ratio,
  output logic              div_valid,
  output logic              out_of_range
);
  localparam int FILL = 3;

  logic [1:0]       fill_q;
  int               total;
  logic             lo_hit, hi_hit;
  logic [INT_W-1:0] clamped;

  always_comb begin
    total  = mash_total(int'(int_word), corr);
    lo_hit = total < DIV_MIN;
    hi_hit = total > DIV_MAX;
    if (lo_hit)      clamped = INT_W'(DIV_MIN);
    else if (hi_hit) clamped = INT_W'(DIV_MAX);
    else             clamped = INT_W'(total);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      fill_q       <= '0;
      div_ratio    <= INT_W'(DIV_MIN);
      div_valid    <= 1'b0;
      out_of_range <= 1'b0;
    end else if (!en) begin
      fill_q    <= '0;
      div_valid <= 1'b0;
    end else begin
      div_valid    <= (fill_q == 2'(FILL));
      if (fill_q != 2'(FILL)) fill_q <= fill_q + 2'd1;
      div_ratio    <= clamped;
      out_of_range <= lo_hit | hi_hit;
    end
  end

  // R8: the ratio never leaves the divider band
  p_ratio_in_band_r8: assert property (@(posedge clk) disable iff (srst)
    (int'(div_ratio) >= DIV_MIN) && (int'(div_ratio) <= DIV_MAX));
  // R9: a raised flag means the ratio sits on a limit
  p_flag_at_limit_r9: assert property (@(posedge clk) disable iff (srst)
    out_of_range |-> (int'(div_ratio) == DIV_MIN || int'(div_ratio) == DIV_MAX));
  // R6: an idle cycle leaves the strobe low
  p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (srst)
    !$past(en) |-> !div_valid);
  // R5: the first edge after enable yields no valid
  p_fill_after_en_r5: assert property (@(posedge clk) disable iff (srst)
    $rose(en) |=> !div_valid);

endmodule

// File: rtl/mash_divratio_mod.sv
module mash_divratio_mod
  import mash_pkg::*;
#(
  parameter int FRAC_W  = 6,
  parameter int INT_W   = 7,
  parameter int DIV_MIN = 64,
  parameter int DIV_MAX = 127
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              en,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic [INT_W-1:0]  int_word,
  output logic [INT_W-1:0]  div_ratio,
  output logic              div_valid,
  output logic              out_of_range
);
  localparam int STAGES = 3;

  logic [FRAC_W-1:0] stage_in [STAGES];
  logic [FRAC_W-1:0] stage_res[STAGES];
  logic [STAGES-1:0] stage_carry;
  logic signed [3:0] corr;

  assign stage_in[0] = frac_word;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k > 0) begin : g_chain
      assign stage_in[k] = stage_res[k-1];
    end
    mash_accum #(.W(FRAC_W)) u_acc (
      .clk     (clk),
      .srst    (srst),
      .en      (en),
      .in_word (stage_in[k]),
      .carry   (stage_carry[k]),
      .residue (stage_res[k])
    );
  end

  mash_recombine u_recomb (
    .clk  (clk),
    .srst (srst),
    .en   (en),
    .c1   (stage_carry[0]),
    .c2   (stage_carry[1]),
    .c3   (stage_carry[2]),
    .corr (corr)
  );

  mash_limit #(.INT_W(INT_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_limit (
    .clk          (clk),
    .srst         (srst),
    .en           (en),
    .int_word     (int_word),
    .corr         (corr),
    .div_ratio    (div_ratio),
    .div_valid    (div_valid),
    .out_of_range (out_of_range)
  );

  // R7: zero fraction with idle accumulators gives no carries
  p_zero_frac_quiet_r7: assert property (@(posedge clk) disable iff (srst)
    (en && frac_word == '0 && stage_res[0] == '0 && stage_res[1] == '0
        && stage_res[2] == '0) |-> (stage_carry == '0));

endmodule

// File: tb/mash_divratio_mod_tb.sv
module mash_divratio_mod_tb;
  localparam int FRAC_W = 6;
  localparam int INT_W  = 7;
  localparam int NPER   = 1 << FRAC_W;
  localparam int MASK   = NPER - 1;

  logic              clk = 1'b0;
  logic              srst = 1'b1;
  logic              en = 1'b0;
  logic [FRAC_W-1:0] frac_word = '0;
  logic [INT_W-1:0]  int_word = 7'd64;
  logic [INT_W-1:0]  div_ratio;
  logic              div_valid;
  logic              out_of_range;

  always #10 clk = ~clk;

  mash_divratio_mod #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_dut (
    .clk(clk), .srst(srst), .en(en), .frac_word(frac_word), .int_word(int_word),
    .div_ratio(div_ratio), .div_valid(div_valid), .out_of_range(out_of_range)
  );

  typedef struct {
    int    ratio;
    bit    valid;
    bit    oor;
    string tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  int msum = 0, mcnt = 0;

  // independent model state
  int a1 = 0, a2 = 0, a3 = 0, d2 = 0, d31 = 0, d32 = 0, fill = 0;
  int m_ratio = 64; bit m_valid = 0; bit m_oor = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int s, c1, c2, c3, y, tot;
    if (srst) begin
      a1 = 0; a2 = 0; a3 = 0; d2 = 0; d31 = 0; d32 = 0; fill = 0;
      m_ratio = 64; m_valid = 0; m_oor = 0;
    end else if (!en) begin
      fill = 0; m_valid = 0;
    end else begin
      s = a1 + int'(frac_word); c1 = s / NPER; a1 = s & MASK;
      s = a2 + a1;              c2 = s / NPER; a2 = s & MASK;
      s = a3 + a2;              c3 = s / NPER; a3 = s & MASK;
      y = c1 + c2 - d2 + c3 - 2 * d31 + d32;
      d2 = c2; d32 = d31; d31 = c3;
      tot = int'(int_word) + y;
      m_valid = (fill == 3);
      if (fill < 3) fill++;
      m_oor = (tot < 64) || (tot > 127);
      m_ratio = (tot < 64) ? 64 : (tot > 127) ? 127 : tot;
    end
  endtask

  task automatic step(bit r, bit e, int f, int i, string tag);
    exp_t x;
    @(negedge clk);
    srst = r; en = e; frac_word = FRAC_W'(f); int_word = INT_W'(i);
    @(posedge clk);
    #1;
    model_edge();
    x.ratio = m_ratio; x.valid = m_valid; x.oor = m_oor; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(int'(div_ratio) == e.ratio, e.tag, "div_ratio", int'(div_ratio), e.ratio);
      check(div_valid == e.valid, e.tag, "div_valid", int'(div_valid), int'(e.valid));
      check(out_of_range == e.oor, e.tag, "out_of_range", int'(out_of_range), int'(e.oor));
      if (div_valid) begin msum += int'(div_ratio); mcnt++; end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int exp_sum;
    // R1 reset state
    step(1, 0, 0, 100, "R1");
    step(1, 0, 0, 100, "R1");
    // R7 zero fraction, with R5 fill
    for (int k = 0; k < 10; k++) step(0, 1, 0, 100, (k < 4) ? "R5" : "R7");
    // R2 R3 R4 carry chain and recombination
    step(1, 0, 13, 86, "R1");
    for (int k = 0; k < 40; k++) step(0, 1, 13, 86, "R2 R3 R4");
    // R6 hold while disabled, then R5 refill
    for (int k = 0; k < 4; k++) step(0, 0, 50, 90, "R6");
    for (int k = 0; k < 8; k++) step(0, 1, 50, 104, "R5");
    // R9 clamp high
    for (int k = 0; k < 30; k++) step(0, 1, 40, 127, "R9");
    // R8 clamp low
    for (int k = 0; k < 30; k++) step(0, 1, 40, 64, "R8");
    for (int k = 0; k < 6; k++) step(0, 1, 0, 40, "R8");
    // R10 long-run mean over one accumulator period
    step(1, 0, 37, 102, "R1");
    step(1, 0, 37, 102, "R1");
    @(negedge clk); #2;
    msum = 0; mcnt = 0;
    for (int k = 0; k < NPER + 3; k++) step(0, 1, 37, 102, "R10");
    step(0, 0, 37, 102, "R6");
    step(0, 0, 37, 102, "R6");
    @(negedge clk); #2;
    exp_sum = 102 * NPER + 37;
    check(mcnt == NPER, "R10", "valid count", mcnt, NPER);
    check((msum - exp_sum) <= 3 && (exp_sum - msum) <= 3, "R10", "sum", msum, exp_sum);
    finish_run();
  end

endmodule